// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides, for an I2C target, whether the address phase of a transfer is acknowledged. A byte-level front end hands it each received byte together with one-cycle indications of a start, a repeated start and a stop condition. The matcher works out which byte is an address byte. It compares that byte against a programmed own address, either 7 or 10 bits wide. A separate don't-care mask can widen the match. The matcher returns an acknowledge decision in the following cycle.

Some address codes are reserved by the bus protocol. These are refused even when the mask would otherwise let them through. The all-zero write address is a general call, and a separate enable decides whether it is accepted. In 10-bit mode the matcher follows the two-byte header sequence. It remembers a completed write match so that a later repeated start can turn the transfer into a read without resending the low address byte. A management-mode enable switches masking off completely.

Top module: `i2c_addr_match`

## Requirements
- R1: A decision (`ack_valid` high for one cycle) appears in the cycle after the `byte_valid` cycle of an address byte. `ack` is high only together with `ack_valid`. `matched`, `rw` and `gcall` take their new values in that same cycle and hold them until the next start, repeated start or stop.
- R2: In 7-bit mode (`ten_bit_en`=0), a first byte is read as address in bits 7..1 and R/W in bit 0 (1 = read). It is acknowledged with `matched`=1 and `rw` equal to bit 0 when every address bit equals `own_addr[6:0]` or has its `addr_mask` bit set to 1. With a single mask bit set, exactly the two addresses that differ in that bit match.
- R3: While `mgmt_en`=1 the mask is ignored and only an exact match is acknowledged.
- R4: A first byte of 0x00 sets `gcall`=1 and `rw`=0. It is acknowledged with `matched`=1 only when `gcall_en`=1; otherwise `ack`=0 and `matched`=0.
- R5: First bytes whose upper four bits are zero, other than 0x00 (start byte, codes 1 to 3, high-speed master codes), and first bytes whose upper five bits are 11111 are never acknowledged, whatever the mask or own address.
- R6: In 7-bit mode a first byte whose upper five bits are 11110 is never acknowledged.
- R7: In 10-bit mode a first byte 11110, A9, A8, 0 is acknowledged with `matched`=0 when A9..A8 match `own_addr[9:8]` under the mask. The next byte is then compared with `own_addr[7:0]` under the mask, and if it matches it is acknowledged with `matched`=1 and `rw`=0. Any other first byte is refused.
- R8: After a completed 10-bit write match, a repeated start followed by 11110, A9, A8, 1 with matching upper bits is acknowledged with `matched`=1 and `rw`=1. The same byte is refused after a plain start, and also when no complete match has been made.
- R9: A stop clears `matched`, `rw` and `gcall`, any half-finished 10-bit header and any remembered 10-bit match. A plain start also drops the remembered match.
- R10: Bytes that arrive after the address decision and before the next start, repeated start or stop produce no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | One-cycle strobe: a received byte is on `byte_data` |
| byte_data | input | 8 | Received byte, most significant bit first on the wire |
| start_det | input | 1 | One-cycle start condition indication |
| rstart_det | input | 1 | One-cycle repeated start indication |
| stop_det | input | 1 | One-cycle stop condition indication |
| own_addr | input | 10 | Own address; bits 6..0 are used in 7-bit mode |
| addr_mask | input | 10 | Per-bit don't-care mask, 1 = ignore that bit |
| ten_bit_en | input | 1 | 1 selects 10-bit addressing |
| gcall_en | input | 1 | 1 lets the general call be acknowledged |
| mgmt_en | input | 1 | 1 disables address masking |
| ack_valid | output | 1 | Decision strobe for the last address byte |
| ack | output | 1 | Acknowledge the last address byte |
| matched | output | 1 | Own address fully matched (or general call accepted) |
| rw | output | 1 | Direction of the addressed transfer, 1 = read |
| gcall | output | 1 | Last decided address was the general call |

## Verification
The bench loads an own address and a mask that covers every bit. It then sends each reserved code and checks that none is acknowledged; a matcher that applied the mask before filtering would acknowledge them all. Single-bit masks are tested against addresses just one bit away, and the same masked address is sent again with management mode on; this shows up a mask that is inverted, applied to the wrong bit, or left active when it should be off. In 10-bit mode the bench sends a read header after a plain start, after a stop, and after a failed low byte. A matcher that kept its 10-bit match state too long would acknowledge these read headers. A low byte sent as the first byte after a stop must also be refused, which exposes header state that survives a stop.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;
  localparam int BYTE_W = 8;
  localparam int A7_W   = 7;
  localparam int A10_W  = 10;
  localparam int HI_W   = A10_W - BYTE_W;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FIRST = 2'd1,
    PH_LOW   = 2'd2,
    PH_DONE  = 2'd3
  } phase_t;

  typedef struct packed {
    logic ack;
    logic matched;
    logic rw;
    logic gcall;
  } verdict_t;
endpackage

// File: rtl/i2cam_rst_sync.sv
module i2cam_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/i2cam_mask_cmp.sv
module i2cam_mask_cmp #(
  parameter int W = 7
) (
  input  logic [W-1:0] rx,
  input  logic [W-1:0] own,
  input  logic [W-1:0] dc,
  output logic         hit
);
  logic [W-1:0] bit_ok;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_ok[i] = dc[i] | ~(rx[i] ^ own[i]);
  end

  assign hit = &bit_ok;
endmodule

// File: rtl/i2cam_classify.sv
module i2cam_classify
  import i2cam_pkg::*;
(
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              is_gc,
  output logic              is_rsv,
  output logic              is_hdr
);
  logic low_band;
  logic top_band;

  always_comb begin
    is_gc    = (rx_byte == '0);
    low_band = (rx_byte[7:4] == 4'b0000) && !is_gc;
    top_band = (rx_byte[7:3] == 5'b11111);
    is_rsv   = low_band | top_band;
    is_hdr   = (rx_byte[7:3] == 5'b11110);
  end
endmodule

// File: rtl/i2cam_seq.sv
module i2cam_seq
  import i2cam_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   byte_valid,
  input  logic   rw_bit,
  input  logic   start_det,
  input  logic   rstart_det,
  input  logic   stop_det,
  input  logic   ten_bit_en,
  input  logic   gcall_en,
  input  logic   is_gc,
  input  logic   is_rsv,
  input  logic   is_hdr,
  input  logic   hit7,
  input  logic   hit_hi,
  input  logic   hit_lo,
  output phase_t phase,
  output logic   ack_valid,
  output verdict_t verdict
);
  phase_t   ph_q, ph_d;
  logic     bound_q, bound_d;
  logic     dv_q, dv_d;
  verdict_t vd_q, vd_d;
  logic     any_ev;
  logic     upd_en;

  always_comb begin
    ph_d    = ph_q;
    bound_d = bound_q;
    dv_d    = 1'b0;
    vd_d    = vd_q;
    vd_d.ack = 1'b0;
    any_ev  = stop_det | start_det | rstart_det;

    if (stop_det) begin
      ph_d    = PH_IDLE;
      bound_d = 1'b0;
      vd_d    = '0;
    end else if (start_det) begin
      ph_d    = PH_FIRST;
      bound_d = 1'b0;
      vd_d    = '0;
    end else if (rstart_det) begin
      ph_d    = PH_FIRST;
      vd_d    = '0;
    end else if (byte_valid) begin
      unique case (ph_q)
        PH_FIRST: begin
          dv_d         = 1'b1;
          ph_d         = PH_DONE;
          bound_d      = 1'b0;
          vd_d.matched = 1'b0;
          vd_d.gcall   = 1'b0;
          vd_d.rw      = rw_bit;
          if (is_gc) begin
            vd_d.gcall   = 1'b1;
            vd_d.ack     = gcall_en;
            vd_d.matched = gcall_en;
          end else if (is_rsv) begin
            vd_d.ack = 1'b0;
          end else if (ten_bit_en) begin
            if (is_hdr && hit_hi) begin
              if (!rw_bit) begin
                vd_d.ack = 1'b1;
                ph_d     = PH_LOW;
              end else if (bound_q) begin
                vd_d.ack     = 1'b1;
                vd_d.matched = 1'b1;
                bound_d      = 1'b1;
              end
            end
          end else if (!is_hdr && hit7) begin
            vd_d.ack     = 1'b1;
            vd_d.matched = 1'b1;
          end
        end
        PH_LOW: begin
          dv_d         = 1'b1;
          ph_d         = PH_DONE;
          vd_d.rw      = 1'b0;
          vd_d.gcall   = 1'b0;
          vd_d.ack     = hit_lo;
          vd_d.matched = hit_lo;
          bound_d      = hit_lo;
        end
        default: begin
          ph_d = ph_q;
        end
      endcase
    end

    upd_en = any_ev | byte_valid | dv_q | vd_q.ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      bound_q <= 1'b0;
      dv_q    <= 1'b0;
      vd_q    <= '0;
    end else if (upd_en) begin
      ph_q    <= ph_d;
      bound_q <= bound_d;
      dv_q    <= dv_d;
      vd_q    <= vd_d;
    end
  end

  assign phase     = ph_q;
  assign ack_valid = dv_q;
  assign verdict   = vd_q;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2cam_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              start_det,
  input  logic              rstart_det,
  input  logic              stop_det,
  input  logic [A10_W-1:0]  own_addr,
  input  logic [A10_W-1:0]  addr_mask,
  input  logic              ten_bit_en,
  input  logic              gcall_en,
  input  logic              mgmt_en,
  output logic              ack_valid,
  output logic              ack,
  output logic              matched,
  output logic              rw,
  output logic              gcall
);
  logic             core_rst_n;
  logic [A10_W-1:0] eff_mask;
  logic             is_gc, is_rsv, is_hdr;
  logic             hit7, hit_hi, hit_lo;
  phase_t           seq_phase;
  verdict_t         vd;

  assign eff_mask = mgmt_en ? '0 : addr_mask;

  i2cam_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  i2cam_classify u_cls (
    .rx_byte (byte_data),
    .is_gc   (is_gc),
    .is_rsv  (is_rsv),
    .is_hdr  (is_hdr)
  );

  i2cam_mask_cmp #(.W(A7_W)) u_cmp7 (
    .rx  (byte_data[BYTE_W-1:1]),
    .own (own_addr[A7_W-1:0]),
    .dc  (eff_mask[A7_W-1:0]),
    .hit (hit7)
  );

  i2cam_mask_cmp #(.W(HI_W)) u_cmp_hi (
    .rx  (byte_data[HI_W:1]),
    .own (own_addr[A10_W-1:BYTE_W]),
    .dc  (eff_mask[A10_W-1:BYTE_W]),
    .hit (hit_hi)
  );

  i2cam_mask_cmp #(.W(BYTE_W)) u_cmp_lo (
    .rx  (byte_data),
    .own (own_addr[BYTE_W-1:0]),
    .dc  (eff_mask[BYTE_W-1:0]),
    .hit (hit_lo)
  );

  i2cam_seq u_seq (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .byte_valid (byte_valid),
    .rw_bit     (byte_data[0]),
    .start_det  (start_det),
    .rstart_det (rstart_det),
    .stop_det   (stop_det),
    .ten_bit_en (ten_bit_en),
    .gcall_en   (gcall_en),
    .is_gc      (is_gc),
    .is_rsv     (is_rsv),
    .is_hdr     (is_hdr),
    .hit7       (hit7),
    .hit_hi     (hit_hi),
    .hit_lo     (hit_lo),
    .phase      (seq_phase),
    .ack_valid  (ack_valid),
    .verdict    (vd)
  );

  assign ack     = vd.ack;
  assign matched = vd.matched;
  assign rw      = vd.rw;
  assign gcall   = vd.gcall;
endmodule

// File: rtl/i2cam_checker.sv
module i2cam_checker
  import i2cam_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       byte_valid,
  input logic [7:0] byte_data,
  input logic       start_det,
  input logic       rstart_det,
  input logic       stop_det,
  input logic       ten_bit_en,
  input logic       gcall_en,
  input phase_t     phase,
  input logic       ack_valid,
  input logic       ack,
  input logic       matched,
  input logic       rw,
  input logic       gcall
);
  logic quiet_bus;
  logic rx_rsv;
  assign quiet_bus = !stop_det && !start_det && !rstart_det;
  assign rx_rsv    = ((byte_data[7:4] == 4'h0) && (byte_data != 8'h00)) ||
                     (byte_data[7:3] == 5'b11111);

  a_r1_ack_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ack_valid);

  a_r1_decision_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(byte_valid));

  a_r5_reserved_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIRST && byte_valid && quiet_bus && rx_rsv) |=> !ack);

  a_r6_header_refused_7bit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIRST && byte_valid && quiet_bus && !ten_bit_en &&
     byte_data[7:3] == 5'b11110) |=> !ack);

  a_r4_gc_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && gcall) |-> (ack == $past(gcall_en)));

  a_r4_gc_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    gcall |-> !rw);

  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!matched && !gcall && !rw && !ack_valid));
endmodule

bind i2c_addr_match i2cam_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_valid (byte_valid),
  .byte_data  (byte_data),
  .start_det  (start_det),
  .rstart_det (rstart_det),
  .stop_det   (stop_det),
  .ten_bit_en (ten_bit_en),
  .gcall_en   (gcall_en),
  .phase      (seq_phase),
  .ack_valid  (ack_valid),
  .ack        (ack),
  .matched    (matched),
  .rw         (rw),
  .gcall      (gcall)
);

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;
  logic       clk;
  logic       rst_n;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       start_det, rstart_det, stop_det;
  logic [9:0] own_addr, addr_mask;
  logic       ten_bit_en, gcall_en, mgmt_en;
  logic       ack_valid, ack, matched, rw, gcall;

  int n_chk;
  int n_bad;
  bit done;

  typedef struct {
    bit    a;
    bit    m;
    bit    r;
    bit    g;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  i2c_addr_match i_i2c_addr_match (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .start_det(start_det), .rstart_det(rstart_det), .stop_det(stop_det),
    .own_addr(own_addr), .addr_mask(addr_mask), .ten_bit_en(ten_bit_en),
    .gcall_en(gcall_en), .mgmt_en(mgmt_en), .ack_valid(ack_valid), .ack(ack),
    .matched(matched), .rw(rw), .gcall(gcall)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // monitor: pops one expected verdict per decision strobe
  always @(negedge clk) begin
    if (rst_n && ack_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected decision: got ack_valid=1 expected 0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (ack !== e.a || matched !== e.m || rw !== e.r || gcall !== e.g) begin
          n_bad++;
          $display("FAIL R1 %s: got ack/m/rw/gc=%b%b%b%b expected %b%b%b%b",
                   e.tag, ack, matched, rw, gcall, e.a, e.m, e.r, e.g);
        end
      end
    end
  end

  task automatic send(input logic [7:0] b, input bit ea, input bit em,
                      input bit er, input bit eg, input string tag);
    exp_t e;
    e.a = ea; e.m = em; e.r = er; e.g = eg; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    byte_data  = b;
    byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic quiet(input logic [7:0] b, input string tag);
    @(negedge clk);
    byte_data  = b;
    byte_valid = 1'b1;
    @(negedge clk);
    byte_valid = 1'b0;
    n_chk++;
    if (ack_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL %s ignored byte: got ack_valid=%b expected 0", tag, ack_valid);
    end
    @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk); start_det = 1'b1;
    @(negedge clk); start_det = 1'b0;
  endtask

  task automatic do_rstart();
    @(negedge clk); rstart_det = 1'b1;
    @(negedge clk); rstart_det = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_det = 1'b1;
    @(negedge clk); stop_det = 1'b0;
  endtask

  task automatic flags(input bit em, input bit er, input bit eg, input string tag);
    n_chk++;
    if (matched !== em || rw !== er || gcall !== eg || ack_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL %s flags: got m/rw/gc/av=%b%b%b%b expected %b%b%b0",
               tag, matched, rw, gcall, ack_valid, em, er, eg);
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; byte_valid = 1'b0; byte_data = '0;
    start_det = 1'b0; rstart_det = 1'b0; stop_det = 1'b0;
    own_addr = 10'h035; addr_mask = '0;
    ten_bit_en = 1'b0; gcall_en = 1'b0; mgmt_en = 1'b0;
    repeat (4) @(negedge clk);
    n_chk++;
    if (ack_valid !== 1'b0 || ack !== 1'b0 || matched !== 1'b0 || rw !== 1'b0 || gcall !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset state: got %b%b%b%b%b expected 00000",
               ack_valid, ack, matched, rw, gcall);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 plain 7-bit
    do_start(); send(8'h6A, 1, 1, 0, 0, "R2 write hit");
    quiet(8'h55, "R10");
    flags(1, 0, 0, "R10 hold");
    do_stop(); flags(0, 0, 0, "R9 stop");
    do_start(); send(8'h6B, 1, 1, 1, 0, "R2 read hit");
    do_rstart(); send(8'h6C, 0, 0, 0, 0, "R2 miss");
    do_stop();

    // R2 single-bit mask: bit 2
    addr_mask = 10'h004;
    do_start(); send(8'h62, 1, 1, 0, 0, "R2 mask twin");
    do_start(); send(8'h6A, 1, 1, 0, 0, "R2 mask own");
    do_start(); send(8'h6E, 0, 0, 0, 0, "R2 mask other bit1");
    do_start(); send(8'h68, 0, 0, 0, 0, "R2 mask other bit0");
    // R3 management mode disables masking
    mgmt_en = 1'b1;
    do_start(); send(8'h62, 0, 0, 0, 0, "R3 mask off twin");
    do_start(); send(8'h6A, 1, 1, 0, 0, "R3 exact");
    mgmt_en = 1'b0;
    do_stop();

    // R4 general call
    do_start(); send(8'h00, 0, 0, 0, 1, "R4 gc disabled");
    gcall_en = 1'b1;
    do_start(); send(8'h00, 1, 1, 0, 1, "R4 gc enabled");
    do_stop();

    // R5 reserved under full mask
    own_addr = 10'h07C; addr_mask = 10'h3FF;
    do_start(); send(8'h01, 0, 0, 1, 0, "R5 start byte");
    do_start(); send(8'h02, 0, 0, 0, 0, "R5 code1");
    do_start(); send(8'h07, 0, 0, 1, 0, "R5 code3");
    do_start(); send(8'h0A, 0, 0, 0, 0, "R5 hs code");
    do_start(); send(8'hF8, 0, 0, 0, 0, "R5 top band");
    do_start(); send(8'hFF, 0, 0, 1, 0, "R5 top band read");
    do_start(); send(8'hA0, 1, 1, 0, 0, "R5 ordinary");
    do_stop();

    // R6 header code in 7-bit mode
    own_addr = 10'h078; addr_mask = '0;
    do_start(); send(8'hF0, 0, 0, 0, 0, "R6 header 7bit");
    do_stop();

    // R7 / R8 10-bit
    ten_bit_en = 1'b1; own_addr = 10'h2A5;
    do_start(); send(8'hF4, 1, 0, 0, 0, "R7 header");
    send(8'hA5, 1, 1, 0, 0, "R7 low hit");
    do_rstart(); send(8'hF5, 1, 1, 1, 0, "R8 read turnaround");
    quiet(8'h12, "R10");
    do_stop();
    do_start(); send(8'hF5, 0, 0, 1, 0, "R8 read no prior");
    do_start(); send(8'hF4, 1, 0, 0, 0, "R7 header");
    send(8'hA4, 0, 0, 0, 0, "R7 low miss");
    do_rstart(); send(8'hF5, 0, 0, 1, 0, "R8 read after miss");
    do_start(); send(8'hF2, 0, 0, 0, 0, "R7 header hi miss");
    do_start(); send(8'h6A, 0, 0, 0, 0, "R7 non-header");
    addr_mask = 10'h001;
    do_start(); send(8'hF4, 1, 0, 0, 0, "R7 header");
    send(8'hA4, 1, 1, 0, 0, "R7 low mask");
    addr_mask = 10'h200;
    do_start(); send(8'hF0, 1, 0, 0, 0, "R7 hi mask");
    send(8'hA5, 1, 1, 0, 0, "R7 low after hi mask");
    addr_mask = '0;
    do_start(); send(8'hF4, 1, 0, 0, 0, "R7 header");
    send(8'hA5, 1, 1, 0, 0, "R7 low hit");
    do_start(); send(8'hF5, 0, 0, 1, 0, "R8 plain start drops");
    // R9 partial header and remembered match cleared by stop
    do_start(); send(8'hF4, 1, 0, 0, 0, "R9 header");
    do_stop(); flags(0, 0, 0, "R9 stop");
    do_start(); send(8'hA5, 0, 0, 1, 0, "R9 stale low");
    do_start(); send(8'hF4, 1, 0, 0, 0, "R9 header");
    send(8'hA5, 1, 1, 0, 0, "R9 low");
    do_stop();
    do_rstart(); send(8'hF5, 0, 0, 1, 0, "R9 stop drops match");
    do_stop();

    repeat (4) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R1 missing decisions: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule